// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns an asynchronous serial line into bytes. It looks for a start bit and shifts in seven or eight data bits, least significant bit first. It then checks an optional parity bit and the first stop bit, and moves the character into a holding register the host reads. The frame format comes from a 3-bit format code. The bit timing comes from a 2-bit rate code, and each receive tick (`clk_en`) stands for one cycle of the receive clock. The block reports four flags: data ready, parity error, framing error and overrun. Each flag has its own rule for when it sets and when it clears.

The rate code picks one of three ratios: one tick per bit, `RATIO_MID` ticks per bit (16 by default) or `RATIO_HIGH` ticks per bit (64 by default). The fourth rate code value is a master reset. It holds the receiver and all flags cleared for as long as it is applied.

At the divided ratios the line is sampled at the middle of each bit. At ratio 1 it is sampled on every tick. A state machine controls the receiver and has these states:
- `ST_IDLE`: waits for a low line.
- `ST_START`: checks the start bit at half a bit time.
- `ST_DATA`: shifts in the data bits.
- `ST_PARITY`: captures the parity bit.
- `ST_STOP`: samples the first stop bit and transfers the character.
- `ST_RECOVER`: after a low stop bit, waits for the line to go high again.

The transitions are:
- IDLE→START: low line at a tick, divided ratio.
- IDLE→DATA: low line at a tick, ratio 1.
- START→IDLE: line high at the half-bit point (start rejected).
- START→DATA: line still low at the half-bit point.
- DATA→PARITY or DATA→STOP: after the last data bit, depending on the format.
- PARITY→STOP: after the parity sample.
- STOP→IDLE: stop bit sampled high.
- STOP→RECOVER: stop bit sampled low.
- RECOVER→IDLE: first tick with the line high.

Top module: `serrx_receiver`

## Requirements
- R1: While `div_sel` is 2'b11 (master reset), the receiver returns to idle and `rdrf`, `overrun`, `parity_err`, `framing_err` and `rx_data` are all cleared. Asynchronous reset has the same effect.
- R2: The format code `word_sel` selects the frame:
  - 000: 7 data bits, even parity, 2 stop bits.
  - 001: 7 data bits, odd parity, 2 stop bits.
  - 010: 7 data bits, even parity, 1 stop bit.
  - 011: 7 data bits, odd parity, 1 stop bit.
  - 100: 8 data bits, no parity, 2 stop bits.
  - 101: 8 data bits, no parity, 1 stop bit.
  - 110: 8 data bits, even parity, 1 stop bit.
  - 111: 8 data bits, odd parity, 1 stop bit.
- R3: At the divided ratios, a low line begins a character only if the line is still low on the tick half a bit time (ratio/2 ticks) after the first low tick. Otherwise the receiver goes back to idle and loads nothing.
- R4: `div_sel` sets the ratio: 00 is 1 tick per bit, 01 is `RATIO_MID` ticks, 10 is `RATIO_HIGH` ticks. At the divided ratios each later bit is sampled a whole bit time after the previous sample point. At ratio 1 each bit is sampled on the tick after the previous one.
- R5: Data bits arrive least significant bit first. In 7-bit formats, bit 7 of `rx_data` reads 0.
- R6: `rdrf` rises on the clock edge at which the first stop bit is sampled. It falls after a `rd_strobe` cycle in which no new character is transferred.
- R7: If a character completes while `rdrf` is 1 and `rd_strobe` is low, `overrun` sets. The new character is discarded, and `rx_data`, `parity_err` and `framing_err` keep their values. `overrun` clears after a `rd_strobe` cycle.
- R8: `framing_err` is loaded with the transferred character and is 1 when the first stop bit is sampled low. A read does not change it; the next transferred character does. Only the first stop bit is checked.
- R9: `parity_err` is loaded with each transferred character and is 1 when the received parity bit does not match the selected parity. In the formats without parity it is 0.
- R10: After a stop bit sampled low, the receiver waits for a tick with the line high before it looks for a new start bit. A break held low for any number of ticks therefore produces exactly one character.
- R11: The state and the bit timing advance only on cycles with `clk_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Receive tick, one pulse per receive clock period |
| rx_line | input | 1 | Serial line, idle high, synchronous to `clk` |
| word_sel | input | 3 | Frame format code (R2) |
| div_sel | input | 2 | Ratio code; 2'b11 is master reset (R1, R4) |
| rd_strobe | input | 1 | One-cycle host read of the received byte |
| rx_data | output | 8 | Received byte |
| rdrf | output | 1 | Received data ready |
| parity_err | output | 1 | Parity error of the held character |
| framing_err | output | 1 | Framing error of the held character |
| overrun | output | 1 | Character lost while the previous one was unread |

## Verification
The hardest case to reach from the ports is a break. The stop bit is sampled low, and the line then stays low well past the frame. A receiver without a recovery wait would read that low line as a new start bit and produce a false character. The bench holds the line low for many extra ticks after a bad stop bit and then sends a valid frame. The per-clock reference model expects exactly one character with a framing error and then the valid one. Start glitches shorter than half a bit, and a frame sent with gaps between ticks, are driven the same way.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_RECOVER
    } rx_state_t;

    typedef enum logic [1:0] {
        DIV_ONE    = 2'b00,
        DIV_MID    = 2'b01,
        DIV_HIGH   = 2'b10,
        DIV_MRESET = 2'b11
    } div_code_t;

    typedef struct packed {
        logic eight_bits;
        logic has_parity;
        logic odd;
    } frame_fmt_t;

    // Format code: [2] selects 8 data bits; code 10x has no parity; [0] selects odd parity.
    function automatic frame_fmt_t decode_fmt(input logic [2:0] code);
        frame_fmt_t f;
        f.eight_bits = code[2];
        f.has_parity = !(code[2] && !code[1]);
        f.odd        = code[0];
        return f;
    endfunction

endpackage

// File: rtl/serrx_sampler.sv
module serrx_sampler
    import serrx_pkg::*;
#(
    parameter int RATIO_MID  = 16,
    parameter int RATIO_HIGH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mreset,
    input  logic       tick,
    input  logic       restart,
    input  logic [1:0] div_sel,
    output logic       half_hit,
    output logic       full_hit
);
    localparam int CNT_W = $clog2(RATIO_HIGH);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] full_lim;
    logic [CNT_W-1:0] half_lim;

    always_comb begin
        unique case (div_sel)
            DIV_MID: begin
                full_lim = CNT_W'(RATIO_MID - 1);
                half_lim = CNT_W'(RATIO_MID / 2 - 1);
            end
            DIV_HIGH: begin
                full_lim = CNT_W'(RATIO_HIGH - 1);
                half_lim = CNT_W'(RATIO_HIGH / 2 - 1);
            end
            default: begin
                full_lim = '0;
                half_lim = '0;
            end
        endcase
    end

    assign half_hit = tick && (cnt_q == half_lim);
    assign full_hit = tick && (cnt_q == full_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (mreset) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (restart || full_hit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/serrx_shifter.sv
module serrx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] shreg,
    output logic              par_acc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            par_acc <= 1'b0;
        end else if (clear) begin
            shreg   <= '0;
            par_acc <= 1'b0;
        end else if (shift_en) begin
            shreg   <= {bit_in, shreg[DATA_W-1:1]};
            par_acc <= par_acc ^ bit_in;
        end
    end

endmodule

// File: rtl/serrx_holding.sv
module serrx_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreset,
    input  logic              load,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] new_data,
    input  logic              new_pe,
    input  logic              new_fe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rdrf,
    output logic              parity_err,
    output logic              framing_err,
    output logic              overrun
);
    logic [DATA_W-1:0] data_q;
    logic rdrf_q, pe_q, fe_q, ovr_q;
    logic accept, lost;

    assign accept = load && (!rdrf_q || rd_strobe);
    assign lost   = load && rdrf_q && !rd_strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            rdrf_q <= 1'b0;
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (mreset) begin
            data_q <= '0;
            rdrf_q <= 1'b0;
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (accept) begin
                data_q <= new_data;
                pe_q   <= new_pe;
                fe_q   <= new_fe;
                rdrf_q <= 1'b1;
            end else if (rd_strobe) begin
                rdrf_q <= 1'b0;
            end
            if (lost) begin
                ovr_q <= 1'b1;
            end else if (rd_strobe) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign rx_data     = data_q;
    assign rdrf        = rdrf_q;
    assign parity_err  = pe_q;
    assign framing_err = fe_q;
    assign overrun     = ovr_q;

endmodule

// File: rtl/serrx_receiver.sv
module serrx_receiver
    import serrx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int RATIO_MID  = 16,
    parameter int RATIO_HIGH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              rx_line,
    input  logic [2:0]        word_sel,
    input  logic [1:0]        div_sel,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rdrf,
    output logic              parity_err,
    output logic              framing_err,
    output logic              overrun
);
    localparam int BITCNT_W = $clog2(DATA_W);
    localparam logic [BITCNT_W-1:0] LAST_LONG  = BITCNT_W'(DATA_W - 1);
    localparam logic [BITCNT_W-1:0] LAST_SHORT = BITCNT_W'(DATA_W - 2);

    frame_fmt_t fmt;
    rx_state_t  state_q, state_d;
    logic       mreset, div_one;
    logic [BITCNT_W-1:0] bit_q;
    logic       pbit_q;
    logic       last_bit;
    logic       half_hit, full_hit;
    logic       restart, sh_clear, shift_en, load;
    logic [DATA_W-1:0] shreg;
    logic       par_acc;
    logic [DATA_W-1:0] new_data;
    logic       new_pe, new_fe;

    assign fmt      = decode_fmt(word_sel);
    assign mreset   = (div_sel == DIV_MRESET);
    assign div_one  = (div_sel == DIV_ONE);
    assign last_bit = (bit_q == (fmt.eight_bits ? LAST_LONG : LAST_SHORT));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (clk_en && !rx_line) state_d = div_one ? ST_DATA : ST_START;
            ST_START:   if (half_hit) state_d = rx_line ? ST_IDLE : ST_DATA;
            ST_DATA:    if (full_hit && last_bit) state_d = fmt.has_parity ? ST_PARITY : ST_STOP;
            ST_PARITY:  if (full_hit) state_d = ST_STOP;
            ST_STOP:    if (full_hit) state_d = rx_line ? ST_IDLE : ST_RECOVER;
            ST_RECOVER: if (clk_en && rx_line) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register with bit count and captured parity bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            pbit_q  <= 1'b0;
        end else if (mreset) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            pbit_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (sh_clear) begin
                bit_q <= '0;
            end else if (shift_en) begin
                bit_q <= bit_q + 1'b1;
            end
            if (state_q == ST_PARITY && full_hit) begin
                pbit_q <= rx_line;
            end
        end
    end

    // Control outputs of the state machine
    always_comb begin
        restart  = 1'b0;
        sh_clear = 1'b0;
        shift_en = 1'b0;
        load     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                restart  = clk_en && !rx_line;
                sh_clear = clk_en && !rx_line;
            end
            ST_START:   restart  = half_hit;
            ST_DATA:    shift_en = full_hit;
            ST_STOP:    load     = full_hit;
            default: ;
        endcase
    end

    assign new_data = fmt.eight_bits ? shreg : {1'b0, shreg[DATA_W-1:1]};
    assign new_pe   = fmt.has_parity && ((par_acc ^ pbit_q) != fmt.odd);
    assign new_fe   = !rx_line;

    serrx_sampler #(
        .RATIO_MID (RATIO_MID),
        .RATIO_HIGH(RATIO_HIGH)
    ) sampler_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mreset  (mreset),
        .tick    (clk_en),
        .restart (restart),
        .div_sel (div_sel),
        .half_hit(half_hit),
        .full_hit(full_hit)
    );

    serrx_shifter #(
        .DATA_W(DATA_W)
    ) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (sh_clear || mreset),
        .shift_en(shift_en),
        .bit_in  (rx_line),
        .shreg   (shreg),
        .par_acc (par_acc)
    );

    serrx_holding #(
        .DATA_W(DATA_W)
    ) holding_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mreset     (mreset),
        .load       (load),
        .rd_strobe  (rd_strobe),
        .new_data   (new_data),
        .new_pe     (new_pe),
        .new_fe     (new_fe),
        .rx_data    (rx_data),
        .rdrf       (rdrf),
        .parity_err (parity_err),
        .framing_err(framing_err),
        .overrun    (overrun)
    );

endmodule

// File: rtl/serrx_receiver_chk.sv
module serrx_receiver_chk
    import serrx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic [2:0]        word_sel,
    input logic [1:0]        div_sel,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] rx_data,
    input logic              rdrf,
    input logic              parity_err,
    input logic              framing_err,
    input logic              overrun,
    input logic              load,
    input rx_state_t         state_q
);
    assert_mreset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == 2'b11) |=> (!rdrf && !overrun && !parity_err && !framing_err));

    assert_read_clears_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !load) |=> !rdrf);

    assert_read_clears_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !overrun);

    assert_overrun_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rdrf));

    assert_short_msb_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !rdrf && !word_sel[2] && div_sel != 2'b11) |=> !rx_data[DATA_W-1]);

    assert_no_parity_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (!rdrf || rd_strobe) && word_sel[2:1] == 2'b10 && div_sel != 2'b11) |=> !parity_err);

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && div_sel != 2'b11) |=> ($stable(framing_err) && $stable(parity_err)));

    assert_no_tick_no_move_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && div_sel != 2'b11) |=> $stable(state_q));

endmodule

bind serrx_receiver serrx_receiver_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .word_sel   (word_sel),
    .div_sel    (div_sel),
    .rd_strobe  (rd_strobe),
    .rx_data    (rx_data),
    .rdrf       (rdrf),
    .parity_err (parity_err),
    .framing_err(framing_err),
    .overrun    (overrun),
    .load       (load),
    .state_q    (state_q)
);

// File: tb/serrx_receiver_tb_top.sv
module serrx_receiver_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b0;
    logic rx_line = 1'b1;
    logic rd_strobe = 1'b0;
    logic [2:0] word_sel = 3'b101;
    logic [1:0] div_sel = 2'b01;
    logic [7:0] rx_data;
    logic rdrf, parity_err, framing_err, overrun;

    int checks = 0;
    int errors = 0;
    int gap = 1;
    bit done = 0;

    // Reference model state
    logic [7:0] m_data = '0;
    logic m_rdrf = 0, m_pe = 0, m_fe = 0, m_ovr = 0;
    logic ev_load = 0;
    logic [7:0] ev_data = '0;
    logic ev_pe = 0, ev_fe = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serrx_receiver dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .rx_line(rx_line),
        .word_sel(word_sel), .div_sel(div_sel), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rdrf(rdrf), .parity_err(parity_err),
        .framing_err(framing_err), .overrun(overrun)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model: R1, R6, R7, R8, R9 flag lifetimes
    always @(posedge clk) begin
        if (!rst_n || div_sel == 2'b11) begin
            m_data <= '0; m_rdrf <= 0; m_pe <= 0; m_fe <= 0; m_ovr <= 0;
        end else begin
            if (ev_load && (!m_rdrf || rd_strobe)) begin
                m_data <= ev_data; m_pe <= ev_pe; m_fe <= ev_fe; m_rdrf <= 1;
            end else if (rd_strobe) begin
                m_rdrf <= 0;
            end
            if (ev_load && m_rdrf && !rd_strobe) m_ovr <= 1;
            else if (rd_strobe) m_ovr <= 0;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 rdrf", rdrf, m_rdrf);
            check("R5 rx_data", rx_data, m_data);
            check("R9 parity_err", parity_err, m_pe);
            check("R8 framing_err", framing_err, m_fe);
            check("R7 overrun", overrun, m_ovr);
        end
    end

    task automatic step(input logic ln, input logic en, input logic ev);
        rx_line = ln; clk_en = en; ev_load = ev;
        @(negedge clk);
        ev_load = 0; clk_en = 0;
    endtask

    task automatic tick_at(input logic ln, input logic ev);
        for (int g = 1; g < gap; g++) step(ln, 1'b0, 1'b0);
        step(ln, 1'b1, ev);
    endtask

    function automatic int ratio();
        case (div_sel)
            2'b00: return 1;
            2'b01: return 16;
            default: return 64;
        endcase
    endfunction

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop, input int extra_low);
        int n = ratio();
        int off = (n == 1) ? 0 : n / 2;
        bit eight = word_sel[2];
        bit haspar = !(word_sel[2] && !word_sel[1]);
        int nb = eight ? 8 : 7;
        logic [7:0] dd = eight ? d : {1'b0, d[6:0]};
        logic p = (^dd) ^ word_sel[0];
        logic bits[$];
        int stop_idx;
        if (bad_par) p = ~p;
        bits.push_back(1'b0);
        for (int k = 0; k < nb; k++) bits.push_back(d[k]);
        if (haspar) bits.push_back(p);
        bits.push_back(!bad_stop);
        stop_idx = bits.size() - 1;
        ev_data = dd; ev_pe = haspar && bad_par; ev_fe = bad_stop;
        for (int i = 0; i < bits.size(); i++)
            for (int t = 0; t < n; t++)
                tick_at(bits[i], (i == stop_idx) && (t == off));
        for (int t = 0; t < extra_low; t++) tick_at(1'b0, 1'b0);
        for (int t = 0; t < 2 * n + 2; t++) tick_at(1'b1, 1'b0);
    endtask

    task automatic do_read();
        rd_strobe = 1;
        @(negedge clk);
        rd_strobe = 0;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset rdrf", rdrf, 0);
        check("R1 reset flags", {parity_err, framing_err, overrun}, 0);

        // R4, R6: 8N1 at ratio 16
        word_sel = 3'b101; div_sel = 2'b01;
        send_frame(8'hA5, 0, 0, 0);
        check("R6 rdrf set", rdrf, 1);
        check("R4 data /16", rx_data, 8'hA5);
        do_read();
        check("R6 rdrf cleared", rdrf, 0);

        // R2, R5: 7E1, bit 7 forced zero
        word_sel = 3'b010;
        send_frame(8'hC3, 0, 0, 0);
        check("R5 msb zero", rx_data, 8'h43);
        check("R9 good parity", parity_err, 0);
        do_read();

        // R9: 7O1 with a wrong parity bit, persists over read, cleared by next load
        word_sel = 3'b011;
        send_frame(8'h5A, 1, 0, 0);
        check("R9 parity set", parity_err, 1);
        do_read();
        check("R9 parity held after read", parity_err, 1);
        send_frame(8'h5A, 0, 0, 0);
        check("R9 parity cleared by load", parity_err, 0);
        do_read();

        // R2: 2-stop short formats
        word_sel = 3'b000; send_frame(8'h11, 0, 0, 0);
        check("R2 7E2 data", rx_data, 8'h11); do_read();
        word_sel = 3'b001; send_frame(8'hFE, 0, 0, 0);
        check("R2 7O2 data", rx_data, 8'h7E); do_read();

        // R9: no parity check in 8N2; 8E1/8O1 detection
        word_sel = 3'b100; send_frame(8'h81, 1, 0, 0);
        check("R9 no parity format", parity_err, 0); do_read();
        word_sel = 3'b110; send_frame(8'h3C, 1, 0, 0);
        check("R9 8E1 bad parity", parity_err, 1); do_read();
        word_sel = 3'b111; send_frame(8'h3D, 0, 0, 0);
        check("R9 8O1 good parity", parity_err, 0); do_read();

        // R8: framing error, kept through a read
        word_sel = 3'b101;
        send_frame(8'h77, 0, 1, 0);
        check("R8 framing set", framing_err, 1);
        check("R8 data loaded", rx_data, 8'h77);
        do_read();
        check("R8 framing held after read", framing_err, 1);
        send_frame(8'h78, 0, 0, 0);
        check("R8 framing cleared by load", framing_err, 0);
        do_read();

        // R10: break held low well beyond the frame
        send_frame(8'h00, 0, 1, 80);
        check("R10 one char after break", rdrf, 1);
        do_read();
        send_frame(8'h96, 0, 0, 0);
        check("R10 recovery data", rx_data, 8'h96);
        check("R10 recovery framing", framing_err, 0);
        do_read();

        // R7: overrun keeps the first character
        send_frame(8'h12, 0, 0, 0);
        send_frame(8'h34, 0, 0, 0);
        check("R7 overrun set", overrun, 1);
        check("R7 first char kept", rx_data, 8'h12);
        do_read();
        check("R7 overrun cleared", overrun, 0);
        check("R7 rdrf cleared", rdrf, 0);

        // R3: short start glitch at ratio 16
        for (int t = 0; t < 3; t++) tick_at(1'b0, 1'b0);
        for (int t = 0; t < 40; t++) tick_at(1'b1, 1'b0);
        check("R3 glitch rejected", rdrf, 0);
        send_frame(8'h69, 0, 0, 0);
        check("R3 next frame ok", rx_data, 8'h69);
        do_read();

        // R4, R3: ratio 64 with a glitch of 20 ticks
        div_sel = 2'b10;
        for (int t = 0; t < 20; t++) tick_at(1'b0, 1'b0);
        for (int t = 0; t < 80; t++) tick_at(1'b1, 1'b0);
        check("R3 glitch /64 rejected", rdrf, 0);
        send_frame(8'hB2, 0, 0, 0);
        check("R4 data /64", rx_data, 8'hB2);
        do_read();

        // R4: ratio 1
        div_sel = 2'b00;
        send_frame(8'h4D, 0, 0, 0);
        check("R4 data /1", rx_data, 8'h4D);
        do_read();

        // R11: ticks every third clock
        div_sel = 2'b01; gap = 3;
        send_frame(8'hE7, 0, 0, 0);
        check("R11 gapped ticks data", rx_data, 8'hE7);
        gap = 1;

        // R1: master reset clears held character and overrun
        send_frame(8'h55, 0, 1, 0);
        check("R1 pre-reset overrun", overrun, 1);
        div_sel = 2'b11;
        repeat (3) @(negedge clk);
        check("R1 mreset rdrf", rdrf, 0);
        check("R1 mreset flags", {parity_err, framing_err, overrun}, 0);
        check("R1 mreset data", rx_data, 0);
        div_sel = 2'b01;
        repeat (2) @(negedge clk);
        send_frame(8'h2B, 0, 0, 0);
        check("R1 receive after mreset", rx_data, 8'h2B);
        do_read();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule